// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is one byte-wide bidirectional port that a small processor drives through a three-register map on a simple single-cycle bus. The map holds an output latch, a write-only direction mask and a per-pin pull-up mask. Each pin can hand its output to an on-chip peripheral through a select input. In that case the peripheral's value, not the latch, drives the pad.

A read of the data register mixes its sources pin by pin. Input pins return the pad level after a two-stage synchronizer. Output pins return whatever is currently driving the pad. Because of this, a software read-modify-write of one bit can rewrite neighbouring latch bits, and the block keeps that behaviour on purpose. A stop input turns every output driver off so the pads float. The registers keep their contents while stop is active.

Top module: `gpio_port_regs`

## Requirements
- R1: After a synchronous active-low reset, the state is as follows:
  - the latch, direction and pull-up registers are all zero (all pins are inputs);
  - `pad_oe`, `pad_pu` and `pad_out` (with no peripheral selected) are zero.
- R2: A write to address 0 (data) changes only the latch, from the next clock edge on. This holds whatever the direction setting. Latch bits on input pins are still stored and later appear on `pad_out`.
- R3: When `bus_rd` is high at address 0, each bit whose direction is 0 (input) returns the pin level.
  - The path from `pin_in` passes through two flops.
  - A change on `pin_in` is therefore visible after the second rising edge, and not after the first.
- R4: When `bus_rd` is high at address 0, each bit whose direction is 1 (output) returns a value chosen by `periph_sel` for that pin:
  - the latch bit when the `periph_sel` bit is 0;
  - the `periph_out` bit when the `periph_sel` bit is 1.
- R5: The direction register is at address 1. Bit value 1 means output and 0 means input. `pad_oe` follows it from the next edge. A read of address 1 returns an undefined value.
- R6: The pull-up register is at address 2 and reads back as written. `pad_pu` is driven only for bits that are inputs (pull-up bit 1 and direction bit 0).
- R7: While `stop_mode` is high, every `pad_oe` bit is 0. Latch and direction keep their values. When `stop_mode` falls, the previous drivers return.
- R8: A read of address 0, a change to one bit, and a write-back of the result loads the read value into the latch, including the untouched bits:
  - input-pin levels or peripheral outputs that differ from the latch replace those latch bits.
- R9: For each pin, `pad_out` equals the `periph_out` bit when its `periph_sel` bit is 1. Otherwise it equals the latch bit.
- R10: `bus_rdata` is 0 whenever `bus_rd` is low. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 2 | Register address (0 data, 1 direction, 2 pull-up) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, valid in the same cycle as `bus_rd` |
| pin_in | input | WIDTH | Pad input levels (asynchronous) |
| periph_sel | input | WIDTH | Per-pin peripheral ownership of the output |
| periph_out | input | WIDTH | Per-pin peripheral output value |
| stop_mode | input | 1 | Standby: all drivers off |
| pad_out | output | WIDTH | Per-pin output value |
| pad_oe | output | WIDTH | Per-pin output enable |
| pad_pu | output | WIDTH | Per-pin pull-up enable |

## Verification
The bench samples an input pin one edge after it changes and then again one edge later. A design that bypassed the synchronizer, or added a third stage, shows its delay in these two samples.

The bench also repeats the bit-set hazard on purpose:
- with input pins that disagree with the latch;
- with a peripheral-owned pin.

A block that read the latch for every bit would leave the neighbouring bits unchanged, and the bench reports that.

Further checks cover:
- pull-up on output pins, which a design that ignored direction would still enable;
- stop mode, where a design might clear the registers or fail to tristate the pads.

// File: rtl/gpio_pkg.sv
// Shared register map for the GPIO port block.
// Assumes a 2-bit word address on the register bus.
package gpio_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_PULL = 2'd2,
        REG_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for asynchronous pad inputs.
// Assumes the inputs are level signals. Each bit is sampled on its own, and
// no bus coherence between bits is claimed.
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the pin levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
// Holds the port latch, direction mask and pull-up mask.
// Assumes single-cycle writes. A write at an unmapped address is dropped.
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  pull_q
);
    logic wr_data, wr_dir, wr_pull;

    // Decode the write strobe into one enable per register.
    always_comb begin
        wr_data = wr && (addr == REG_DATA);
        wr_dir  = wr && (addr == REG_DIR);
        wr_pull = wr && (addr == REG_PULL);
    end

    // Port latch: loaded on any data write, whatever the direction setting.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= '0;
        else if (wr_data) latch_q <= wdata;
    end

    // Direction mask: 1 means output. Write-only from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // Pull-up mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       pull_q <= '0;
        else if (wr_pull) pull_q <= wdata;
    end

    AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == REG_DATA) |=> (latch_q == $past(wdata))); // R2
    AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == REG_DIR) |=> $stable(dir_q)); // R7
endmodule

// File: rtl/gpio_pad_ctl.sv
// Per-pin pad control: output source, driver enable and pull-up gating.
// Assumes stop_mode is already synchronous to clk.
module gpio_pad_ctl #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pull_q,
    input  logic [WIDTH-1:0] periph_sel,
    input  logic [WIDTH-1:0] periph_out,
    input  logic             stop_mode,
    output logic [WIDTH-1:0] drv_val,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Choose the driver source, gate the enable with stop and the pull-up with direction.
        always_comb begin
            drv_val[i] = periph_sel[i] ? periph_out[i] : latch_q[i];
            pad_oe[i]  = dir_q[i] && !stop_mode;
            pad_pu[i]  = pull_q[i] && !dir_q[i];
        end
    end

    AST_STOP_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |-> (pad_oe == '0)); // R7
    AST_PULL_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & dir_q) == '0)); // R6
endmodule

// File: rtl/gpio_rd_mux.sv
// Read-data multiplexer for the register bus.
// Assumes a combinational read: rdata is valid in the cycle rd is high.
// The direction address returns zero, and software must treat that value as undefined.
module gpio_rd_mux
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  pin_sync,
    input  logic [WIDTH-1:0]  drv_val,
    input  logic [WIDTH-1:0]  dir_q,
    input  logic [WIDTH-1:0]  pull_q,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] data_view;

    // Per pin: the pad level for inputs, the driven value for outputs.
    always_comb begin
        for (int i = 0; i < WIDTH; i++)
            data_view[i] = dir_q[i] ? drv_val[i] : pin_sync[i];
    end

    // Select the register that appears on the read bus.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                REG_DATA: rdata = data_view;
                REG_PULL: rdata = pull_q;
                default:  rdata = '0;
            endcase
        end
    end

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (rdata == '0)); // R10
endmodule

// File: rtl/gpio_port_regs.sv
// Top of the GPIO port: register file, input synchronizer, pad control
// and read multiplexer.
// Assumes a single-cycle bus with separate read and write strobes.
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    input  logic [WIDTH-1:0]  periph_sel,
    input  logic [WIDTH-1:0]  periph_out,
    input  logic              stop_mode,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu
);
    logic [WIDTH-1:0] latch_q, dir_q, pull_q, pin_sync, drv_val;

    gpio_regfile #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
        .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .dir_q(dir_q),
        .pull_q(pull_q), .periph_sel(periph_sel), .periph_out(periph_out),
        .stop_mode(stop_mode), .drv_val(drv_val), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    gpio_rd_mux #(.WIDTH(WIDTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr),
        .pin_sync(pin_sync), .drv_val(drv_val), .dir_q(dir_q),
        .pull_q(pull_q), .rdata(bus_rdata)
    );

    assign pad_out = drv_val;

    AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DIR && !stop_mode) |=>
        (stop_mode || pad_oe == $past(bus_wdata))); // R5
endmodule

// File: tb/gpio_port_regs_tb.sv
// Directed bench for gpio_port_regs. One task per scenario.
module gpio_port_regs_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   bus_addr;
    logic         bus_wr, bus_rd, stop_mode;
    logic [W-1:0] bus_wdata, bus_rdata, pin_in, periph_sel, periph_out;
    logic [W-1:0] pad_out, pad_oe, pad_pu;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_port_regs #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .periph_sel(periph_sel), .periph_out(periph_out),
        .stop_mode(stop_mode), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "pad_oe", pad_oe, 8'h00);
        check("R1", "pad_pu", pad_pu, 8'h00);
        check("R1", "pad_out", pad_out, 8'h00);
        check("R10", "idle rdata", bus_rdata, 8'h00);
    endtask

    task automatic t_latch_write();
        logic [W-1:0] d;
        bus_write(2'd0, 8'hA5);
        check("R2", "latch on input pins", pad_out, 8'hA5);
        check("R2", "oe unchanged", pad_oe, 8'h00);
        bus_write(2'd1, 8'hFF);
        check("R5", "oe follows dir", pad_oe, 8'hFF);
        bus_read(2'd0, d);
        check("R4", "output read = latch", d, 8'hA5);
    endtask

    task automatic t_input_sync();
        logic [W-1:0] d;
        bus_write(2'd1, 8'h0F);
        @(negedge clk);
        pin_in = 8'hF0;
        @(negedge clk);
        d = 8'h00;
        bus_addr = 2'd0; bus_rd = 1'b1;
        #2 d = bus_rdata;
        check("R3", "one edge: old level", d, 8'h05);
        @(negedge clk);
        #2 d = bus_rdata;
        check("R3", "two edges: new level", d, 8'hF5);
        bus_rd = 1'b0;
    endtask

    task automatic t_periph();
        logic [W-1:0] d;
        bus_write(2'd1, 8'hFF);
        @(negedge clk);
        periph_sel = 8'h81; periph_out = 8'h01;
        #2;
        check("R9", "pad_out mix", pad_out, 8'h25);
        bus_read(2'd0, d);
        check("R4", "peripheral read", d, 8'h25);
        @(negedge clk);
        periph_sel = 8'h00; periph_out = 8'h00;
    endtask

    task automatic t_pullup();
        logic [W-1:0] d;
        bus_write(2'd1, 8'h0F);
        bus_write(2'd2, 8'hFF);
        check("R6", "pull-up on inputs only", pad_pu, 8'hF0);
        bus_read(2'd2, d);
        check("R6", "pull-up readback", d, 8'hFF);
        bus_write(2'd2, 8'h00);
    endtask

    task automatic t_stop();
        logic [W-1:0] d;
        bus_write(2'd1, 8'hFF);
        @(negedge clk);
        stop_mode = 1'b1;
        #2;
        check("R7", "stop tristates", pad_oe, 8'h00);
        @(negedge clk);
        stop_mode = 1'b0;
        #2;
        check("R7", "drivers restored", pad_oe, 8'hFF);
        bus_read(2'd0, d);
        check("R7", "latch kept", d, 8'hA5);
    endtask

    task automatic t_rmw();
        logic [W-1:0] d;
        bus_write(2'd0, 8'h55);
        bus_write(2'd1, 8'h0F);
        bus_read(2'd0, d);
        bus_write(2'd0, d | 8'h02);
        bus_write(2'd1, 8'hFF);
        check("R8", "input bits copied", pad_out, 8'hF7);
        @(negedge clk);
        periph_sel = 8'h01; periph_out = 8'h00;
        bus_read(2'd0, d);
        bus_write(2'd0, d & 8'h7F);
        @(negedge clk);
        periph_sel = 8'h00;
        #2;
        check("R8", "peripheral bit copied", pad_out, 8'h76);
    endtask

    task automatic t_idle();
        logic [W-1:0] d;
        bus_read(2'd3, d);
        check("R10", "unmapped read", d, 8'h00);
        @(negedge clk);
        bus_addr = 2'd2;
        #2;
        check("R10", "no strobe", bus_rdata, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_wdata = '0; pin_in = '0; periph_sel = '0; periph_out = '0;
        stop_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch_write();
        t_input_sync();
        t_periph();
        t_pullup();
        t_stop();
        t_rmw();
        t_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule